// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer

This block is the control sequencer of a small 32-bit processor. It moves through three phases in a fixed rotation: fetch, then decode, then execute, then fetch again. It advances only on cycles where the clock enable `step_en` is high. During fetch it reads the instruction one byte per enabled cycle from a byte-addressed memory port, starting at the program counter. It builds a big-endian word from those bytes. When the last byte arrives it moves the program counter on by one word and records the address the instruction came from.

Decode and execute are done by logic outside this block. That logic reports back through plain status inputs with no handshake. Each enabled cycle, the sequencer turns the status of the active phase into a stage error code. A failing phase is not left: it is repeated on the next enabled cycle. An instruction that completes execution while `halt_req` is high freezes the sequencer until reset.

Top module: `fde_sequencer`

## Requirements
- R1: After reset, `pc` is 0, the fetch phase is active (`fetch_active`=1), `err_code` is 0, `halted` is 0 and `mem_addr` is 0.
- R2: At most one of `fetch_active`, `decode_active` and `exec_active` is high at any time. Phases run in the order fetch → decode → execute → fetch, and each advance needs a successful enabled cycle.
- R3: Fetch takes four successful enabled cycles. On each of them `mem_addr` = `pc` + byte index (0..3). The byte read at index 0 becomes `instr_word[31:24]`, index 1 becomes [23:16], index 2 becomes [15:8] and index 3 becomes [7:0].
- R4: When the fourth byte is captured, `pc` grows by 4 and `instr_addr` takes the old `pc` value. The phase then becomes decode. `pc` never changes in any other way except through reset.
- R5: On a cycle with `step_en` low, none of `pc`, the phase, the byte index, `err_code` or `halted` changes.
- R6: A fetch cycle with `mem_fault`=1 sets `err_code` to 3. That cycle captures no byte, and the byte index and `mem_addr` stay the same.
- R7: In decode, `dec_fault`=1 sets `err_code` to 2 and keeps the phase at decode. `dec_fault`=0 sets `err_code` to 0 and moves to execute.
- R8: In execute, `exec_status` 0 gives `err_code` 0 and moves to fetch. A value of 2 gives `err_code` 4 (internal fault). A value of 1 or 3 gives `err_code` 1. With any nonzero value the phase stays at execute.
- R9: If execute succeeds while `halt_req`=1, `halted` becomes 1 and stays 1 until reset. While halted, all three phase strobes are low and `pc` is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Clock enable; one sequencing step per high cycle |
| mem_addr | output | 32 | Byte address of the current fetch read |
| mem_rdata | input | 8 | Byte returned for `mem_addr` in the same cycle |
| mem_fault | input | 1 | Memory read failure during fetch |
| dec_fault | input | 1 | Decode failure reported by the decoder |
| exec_status | input | 2 | Execute result: 0 ok, 1 fault, 2 internal fault, 3 fault |
| halt_req | input | 1 | Halt request, taken when execute succeeds |
| instr_word | output | 32 | Assembled instruction word |
| instr_addr | output | 32 | Address of the word in `instr_word` |
| pc | output | 32 | Program counter |
| fetch_active | output | 1 | Fetch phase strobe |
| decode_active | output | 1 | Decode phase strobe |
| exec_active | output | 1 | Execute phase strobe |
| err_code | output | 3 | Stage error code of the last enabled step |
| halted | output | 1 | Sequencer frozen by a halt |

## Verification
The assertions assume that `mem_rdata` is valid in the same cycle `mem_addr` is presented. They also assume the status inputs are meaningful only in the phase they belong to, and that `step_en`, the faults and `halt_req` are known values whenever reset is released. The stimulus changes every input only on the falling clock edge. It serves bytes from a small memory model that reads combinationally, and it raises each fault input only in the phase that owns it. This keeps the checks within those assumptions.

// File: rtl/fde_seq_pkg.sv
package fde_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    localparam logic [2:0] CODE_OK       = 3'd0;
    localparam logic [2:0] CODE_EXEC     = 3'd1;
    localparam logic [2:0] CODE_DECODE   = 3'd2;
    localparam logic [2:0] CODE_FETCH    = 3'd3;
    localparam logic [2:0] CODE_INTERNAL = 3'd4;

    localparam logic [1:0] EXST_OK       = 2'd0;
    localparam logic [1:0] EXST_INTERNAL = 2'd2;

endpackage

// File: rtl/fde_byte_lanes.sv
// Places one byte into a word; lane 0 lands in the most significant byte.
module fde_byte_lanes #(
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [7:0]        byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [WORD_W-1:0] word_o
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        localparam int LSB = (WORD_BYTES - 1 - g) * 8;
        assign word_o[LSB +: 8] = (idx_i == IDX_W'(g)) ? byte_i : word_i[LSB +: 8];
    end
endmodule

// File: rtl/fde_status_map.sv
// Turns the active phase's status inputs into a stage code and a fault flag.
module fde_status_map
    import fde_seq_pkg::*;
(
    input  phase_e      phase_i,
    input  logic        mem_fault_i,
    input  logic        dec_fault_i,
    input  logic [1:0]  exec_status_i,
    output logic        fault_o,
    output logic [2:0]  code_o
);
    always_comb begin
        code_o = CODE_OK;
        unique case (phase_i)
            PH_FETCH:  if (mem_fault_i) code_o = CODE_FETCH;
            PH_DECODE: if (dec_fault_i) code_o = CODE_DECODE;
            PH_EXEC: begin
                if (exec_status_i == EXST_INTERNAL)   code_o = CODE_INTERNAL;
                else if (exec_status_i != EXST_OK)    code_o = CODE_EXEC;
            end
            default:   code_o = CODE_INTERNAL;
        endcase
        fault_o = (code_o != CODE_OK);
    end
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
    import fde_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_fault,
    input  logic              dec_fault,
    input  logic [1:0]        exec_status,
    input  logic              halt_req,
    output logic [WORD_W-1:0] instr_word,
    output logic [ADDR_W-1:0] instr_addr,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch_active,
    output logic              decode_active,
    output logic              exec_active,
    output logic [2:0]        err_code,
    output logic              halted
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   iaddr;
        logic [WORD_W-1:0]   word;
        logic [2:0]          code;
        logic                halted;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [WORD_W-1:0] merged_word;
    logic              stage_fault;
    logic [2:0]        stage_code;
    logic              go;

    fde_byte_lanes #(.WORD_BYTES(WORD_BYTES)) u_lanes (
        .word_i (state_q.word),
        .byte_i (mem_rdata),
        .idx_i  (state_q.idx),
        .word_o (merged_word)
    );

    fde_status_map u_status (
        .phase_i       (state_q.phase),
        .mem_fault_i   (mem_fault),
        .dec_fault_i   (dec_fault),
        .exec_status_i (exec_status),
        .fault_o       (stage_fault),
        .code_o        (stage_code)
    );

    assign go = step_en && !state_q.halted;

    always_comb begin
        state_d = state_q;
        if (go) begin
            state_d.code = stage_code;
            unique case (state_q.phase)
                PH_FETCH: begin
                    if (!stage_fault) begin
                        state_d.word = merged_word;
                        if (state_q.idx == LAST_IDX) begin
                            state_d.idx   = '0;
                            state_d.pc    = state_q.pc + ADDR_W'(WORD_BYTES);
                            state_d.iaddr = state_q.pc;
                            state_d.phase = PH_DECODE;
                        end else begin
                            state_d.idx = state_q.idx + IDX_W'(1);
                        end
                    end
                end
                PH_DECODE: if (!stage_fault) state_d.phase = PH_EXEC;
                PH_EXEC: begin
                    if (!stage_fault) begin
                        state_d.phase = PH_FETCH;
                        if (halt_req) state_d.halted = 1'b1;
                    end
                end
                default: state_d.phase = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.phase  <= PH_FETCH;
            state_q.idx    <= '0;
            state_q.pc     <= '0;
            state_q.iaddr  <= '0;
            state_q.word   <= '0;
            state_q.code   <= CODE_OK;
            state_q.halted <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_addr      = state_q.pc + ADDR_W'(state_q.idx);
    assign instr_word    = state_q.word;
    assign instr_addr    = state_q.iaddr;
    assign pc            = state_q.pc;
    assign err_code      = state_q.code;
    assign halted        = state_q.halted;
    assign fetch_active  = !state_q.halted && (state_q.phase == PH_FETCH);
    assign decode_active = !state_q.halted && (state_q.phase == PH_DECODE);
    assign exec_active   = !state_q.halted && (state_q.phase == PH_EXEC);

endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_fault,
    input logic              dec_fault,
    input logic [ADDR_W-1:0] pc,
    input logic              fetch_active,
    input logic              decode_active,
    input logic              exec_active,
    input logic [2:0]        err_code,
    input logic              halted
);
    assert_strobes_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_active, decode_active, exec_active}));

    assert_pc_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> (pc == $past(pc) + ADDR_W'(WORD_BYTES)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(pc) && $stable(err_code) && $stable(mem_addr)
                      && $stable(fetch_active) && $stable(decode_active)));

    assert_fetch_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && fetch_active && mem_fault) |=>
            (err_code == 3'd3 && $stable(mem_addr) && fetch_active));

    assert_decode_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && decode_active && dec_fault) |=> (err_code == 3'd2 && decode_active));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));
endmodule

bind fde_sequencer fde_sequencer_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/fde_sequencer_tb.sv
`timescale 1ns/1ps
module fde_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        mem_fault = 1'b0;
    logic        dec_fault = 1'b0;
    logic [1:0]  exec_status = 2'd0;
    logic        halt_req = 1'b0;
    logic [31:0] instr_word, instr_addr, pc;
    logic        fetch_active, decode_active, exec_active, halted;
    logic [2:0]  err_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct packed { logic [31:0] w; logic [31:0] a; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return 8'((a[5:0] * 37) + 11);
    endfunction

    assign mem_rdata = mbyte(mem_addr);

    fde_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .dec_fault(dec_fault),
        .exec_status(exec_status), .halt_req(halt_req), .instr_word(instr_word),
        .instr_addr(instr_addr), .pc(pc), .fetch_active(fetch_active),
        .decode_active(decode_active), .exec_active(exec_active),
        .err_code(err_code), .halted(halted)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side: expected fetch result for an instruction at address a
    task automatic expect_instr(input logic [31:0] a);
        exp_t e;
        e.w = {mbyte(a), mbyte(a + 1), mbyte(a + 2), mbyte(a + 3)};
        e.a = a;
        sb.push_back(e);
    endtask

    task automatic stp();
        @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: on entry to decode, compare assembled word and its address
    logic dec_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && decode_active && !dec_prev) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected word", instr_word, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(instr_word == e.w, "R3 word", instr_word, e.w);
                chk(instr_addr == e.a, "R4 instr_addr", instr_addr, e.a);
            end
        end
        dec_prev = decode_active;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(pc == 0, "R1 pc", pc, 0);
        chk(fetch_active && !decode_active && !exec_active, "R1 phase", {fetch_active, decode_active, exec_active}, 3'b100);
        chk(err_code == 0, "R1 err", err_code, 0);
        chk(halted == 0, "R1 halted", halted, 0);
        chk(mem_addr == 0, "R1 mem_addr", mem_addr, 0);

        // instruction at 0, with idle cycles in the middle
        expect_instr(32'd0);
        step_en = 1'b1; stp();
        chk(mem_addr == 1, "R3 byte index addr", mem_addr, 1);
        step_en = 1'b0; stp(); stp();
        chk(mem_addr == 1 && pc == 0, "R5 idle addr", mem_addr, 1);
        chk(fetch_active, "R5 idle phase", fetch_active, 1);
        step_en = 1'b1; stp();
        chk(mem_addr == 2, "R3 byte index addr 2", mem_addr, 2);
        stp(); stp();
        chk(pc == 4, "R4 pc advance", pc, 4);
        chk(decode_active && !fetch_active, "R2 to decode", {fetch_active, decode_active, exec_active}, 3'b010);

        dec_fault = 1'b1; stp();
        chk(err_code == 2 && decode_active, "R7 decode fault", err_code, 2);
        dec_fault = 1'b0; stp();
        chk(err_code == 0 && exec_active, "R7 decode ok", err_code, 0);

        exec_status = 2'd2; stp();
        chk(err_code == 4 && exec_active, "R8 internal", err_code, 4);
        exec_status = 2'd1; stp();
        chk(err_code == 1 && exec_active, "R8 fault 1", err_code, 1);
        exec_status = 2'd3; stp();
        chk(err_code == 1 && exec_active, "R8 fault 3", err_code, 1);
        exec_status = 2'd0; stp();
        chk(err_code == 0 && fetch_active, "R2 back to fetch", err_code, 0);
        chk(pc == 4, "R4 pc held outside fetch", pc, 4);

        // instruction at 4, with a memory fault on byte 2
        expect_instr(32'd4);
        stp(); stp();
        mem_fault = 1'b1; stp();
        chk(err_code == 3, "R6 fetch fault code", err_code, 3);
        chk(mem_addr == 6 && fetch_active, "R6 index held", mem_addr, 6);
        mem_fault = 1'b0; stp();
        chk(err_code == 0 && mem_addr == 7, "R6 retry", mem_addr, 7);
        stp();
        chk(pc == 8 && decode_active, "R4 second pc", pc, 8);

        stp();
        halt_req = 1'b1; stp();
        chk(halted == 1, "R9 halted", halted, 1);
        chk({fetch_active, decode_active, exec_active} == 3'b000, "R9 strobes", {fetch_active, decode_active, exec_active}, 0);
        halt_req = 1'b0; stp(); stp();
        chk(halted == 1 && pc == 8, "R9 frozen", pc, 8);
        chk(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule